// File: doc/BRIEF.md
# Event-Driven Interrupt Timer with Selectable Source

This block is a programmable interrupt timer. Every clock it may see a single-cycle strobe from one of four event sources: a CPU clock edge, a rising PPU A12 line, a PPU read or a CPU write. The edge detection for these strobes is done outside the block. A control register picks which strobe counts. Each counted strobe steps an 8-bit prescaler. When the prescaler wraps, it steps an 8-bit counter. When the counter wraps, the interrupt line goes high. The prescaler can wrap at 256 events or at 8 events, and counting can run upward, downward or not at all.

Software reaches the block through a write-only register page of eight addresses. Loads of the prescaler and the counter are XOR-scrambled with a key held in another register of the page. Enabling and disabling are separate operations. A disable also serves as the interrupt acknowledge. One register slot holds an extra configuration byte, which is stored but changes nothing.

Top module: `evt_irq_timer`

## Requirements
- R1: A write is taken only when address bits 15:12 equal 0xC. Bits 2:0 pick the register (0..7) and bits 11:3 are ignored. A write to any other page changes nothing.
- R2: A write to register 0 enables the timer when data bit 0 is 1 and disables it when bit 0 is 0. Register 2 always disables and register 3 always enables.
- R3: A disable clears the interrupt and sets the prescaler to zero. While the timer is disabled, no strobe changes the prescaler or the counter.
- R4: A write to register 4 loads the prescaler, and a write to register 5 loads the counter. In both cases the stored value is the written data XOR the key in register 6. After reset the key is zero.
- R5: Register 1 bits 1:0 choose the counted strobe: 0 CPU clock, 1 PPU A12 rise, 2 PPU read, 3 CPU write. Strobes from the other sources are not counted.
- R6: Register 1 bit 2 = 0 makes the prescaler wrap across all 8 bits (256 events per counter step). Bit 2 = 1 makes only bits 2:0 step (8 events per counter step), and prescaler bits 7:3 are left unchanged.
- R7: Register 1 bits 7:6 set the direction: 1 counts up, 2 counts down, and 0 or 3 count nothing. Going up, the prescaler wraps at the mask value and the counter at 0xFF. Going down, both wrap at zero.
- R8: When a counted strobe wraps both the prescaler and the counter, the interrupt goes high on the next clock edge. It stays high through any later strobes until a disable.
- R9: After reset the timer is disabled, the interrupt is low, and every register is zero (direction 0, source 0, full mask, key 0).
- R10: Register 7 and register 1 bit 3 are accepted but do not change counting or the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| evt_cpu_clk | input | 1 | CPU clock rise strobe (source 0) |
| evt_ppu_a12 | input | 1 | PPU A12 rise strobe (source 1) |
| evt_ppu_rd | input | 1 | PPU read strobe (source 2) |
| evt_cpu_wr | input | 1 | CPU write strobe (source 3) |
| irq | output | 1 | Interrupt request, active high |

## Verification
The embedded properties hold on every cycle for these behaviours:
- Writes outside the register page leave the registers unchanged.
- A disable drops the interrupt and zeroes the prescaler.
- The interrupt stays high until a disable, and it rises only after a strobe that steps the counter from its wrap value.
- In narrow mode the upper prescaler bits do not move.

Other behaviours need the bench's scenarios, which count events to the exact strobe that raises the interrupt: the number of events per counter step in each mask mode, the XOR scrambling of loads, source selection, down counting, and the fact that the extra register has no effect.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        DIR_HOLD_LO = 2'd0,
        DIR_UP      = 2'd1,
        DIR_DOWN    = 2'd2,
        DIR_HOLD_HI = 2'd3
    } dir_e;

    localparam int NUM_SRC  = 4;
    localparam int SEL_W    = 3;
    localparam int PAGE_W   = 4;

    localparam logic [SEL_W-1:0] RG_ENA_BIT  = 3'd0;
    localparam logic [SEL_W-1:0] RG_MODE     = 3'd1;
    localparam logic [SEL_W-1:0] RG_DISABLE  = 3'd2;
    localparam logic [SEL_W-1:0] RG_ENABLE   = 3'd3;
    localparam logic [SEL_W-1:0] RG_PRE_LD   = 3'd4;
    localparam logic [SEL_W-1:0] RG_CNT_LD   = 3'd5;
    localparam logic [SEL_W-1:0] RG_KEY      = 3'd6;
    localparam logic [SEL_W-1:0] RG_AUX      = 3'd7;

    typedef struct packed {
        dir_e       dir;
        logic [1:0] spare;
        logic       aux_en;
        logic       narrow;
        logic [1:0] src;
    } mode_t;

endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
    import evt_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 8,
    parameter logic [PAGE_W-1:0] PAGE   = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              en_o,
    output dir_e              dir_o,
    output logic              narrow_o,
    output logic [1:0]        src_o,
    output logic              dis_o,
    output logic              pre_ld_o,
    output logic              cnt_ld_o,
    output logic [DATA_W-1:0] ld_val_o
);

    typedef struct packed {
        logic              en;
        mode_t             mode;
        logic [DATA_W-1:0] key;
        logic [DATA_W-1:0] aux;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  dis_d, pre_ld_d, cnt_ld_d;

    logic              page_hit;
    logic [SEL_W-1:0]  sel;
    logic              field_unused;

    assign page_hit = wr_en && (wr_addr[ADDR_W-1 -: PAGE_W] == PAGE);
    assign sel      = wr_addr[SEL_W-1:0];

    always_comb begin
        regs_d   = regs_q;
        dis_d    = 1'b0;
        pre_ld_d = 1'b0;
        cnt_ld_d = 1'b0;
        if (page_hit) begin
            unique case (sel)
                RG_ENA_BIT: begin
                    regs_d.en = wr_data[0];
                    dis_d     = ~wr_data[0];
                end
                RG_MODE:    regs_d.mode = mode_t'(wr_data[7:0]);
                RG_DISABLE: begin
                    regs_d.en = 1'b0;
                    dis_d     = 1'b1;
                end
                RG_ENABLE:  regs_d.en = 1'b1;
                RG_PRE_LD:  pre_ld_d = 1'b1;
                RG_CNT_LD:  cnt_ld_d = 1'b1;
                RG_KEY:     regs_d.key = wr_data;
                RG_AUX:     regs_d.aux = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en_o     = regs_q.en;
    assign dir_o    = regs_q.mode.dir;
    assign narrow_o = regs_q.mode.narrow;
    assign src_o    = regs_q.mode.src;
    assign dis_o    = dis_d;
    assign pre_ld_o = pre_ld_d;
    assign cnt_ld_o = cnt_ld_d;
    assign ld_val_o = wr_data ^ regs_q.key;

    // Stored configuration with no function, and address bits outside the decode.
    assign field_unused = ^{regs_q.aux, regs_q.mode.aux_en, regs_q.mode.spare,
                            wr_addr[ADDR_W-PAGE_W-1:SEL_W]};

    AST_OFF_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[ADDR_W-1 -: PAGE_W] != PAGE) |=> $stable(regs_q)) // R1
        else $error("off-page write changed a register");

    AST_OFF_PAGE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !page_hit |-> !(dis_o || pre_ld_o || cnt_ld_o)) // R1
        else $error("pulse without page hit");

endmodule

// File: rtl/evt_src_select.sv
module evt_src_select
    import evt_pkg::*;
(
    input  logic               en_i,
    input  dir_e               dir_i,
    input  logic [1:0]         src_i,
    input  logic [NUM_SRC-1:0] strobe_i,
    output logic               tick_o,
    output logic               down_o
);

    logic [NUM_SRC-1:0] hit;
    logic               dir_active;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = strobe_i[g] && (src_i == 2'(g));
    end

    always_comb begin
        dir_active = (dir_i == DIR_UP) || (dir_i == DIR_DOWN);
        tick_o     = en_i && dir_active && (|hit);
        down_o     = (dir_i == DIR_DOWN);
    end

    always_comb begin
        if (tick_o) begin
            AST_TICK_NEEDS_STROBE: assert (strobe_i[src_i]) // R5
                else $error("tick without selected strobe");
        end
    end

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
    parameter int W           = 8,
    parameter int NARROW_BITS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         down_i,
    input  logic         narrow_i,
    input  logic         dis_i,
    input  logic         pre_ld_i,
    input  logic         cnt_ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic         irq_o
);

    localparam logic [W-1:0] FULL_MASK   = '1;
    localparam logic [W-1:0] NARROW_MASK = W'((1 << NARROW_BITS) - 1);

    typedef struct packed {
        logic [W-1:0] pre;
        logic [W-1:0] cnt;
        logic         irq;
    } core_t;

    core_t core_d, core_q;

    logic [W-1:0] mask;
    logic [W-1:0] pre_masked;
    logic [W-1:0] pre_moved;
    logic [W-1:0] pre_step;
    logic [W-1:0] cnt_step;
    logic         pre_wrap;
    logic         cnt_wrap;

    always_comb begin
        mask       = narrow_i ? NARROW_MASK : FULL_MASK;
        pre_masked = core_q.pre & mask;
        if (down_i) begin
            pre_wrap  = (pre_masked == '0);
            pre_moved = core_q.pre - W'(1);
            cnt_wrap  = (core_q.cnt == '0);
            cnt_step  = core_q.cnt - W'(1);
        end else begin
            pre_wrap  = (pre_masked == mask);
            pre_moved = core_q.pre + W'(1);
            cnt_wrap  = (core_q.cnt == '1);
            cnt_step  = core_q.cnt + W'(1);
        end
        pre_step = (core_q.pre & ~mask) | (pre_moved & mask);

        core_d = core_q;
        if (dis_i) begin
            core_d.pre = '0;
            core_d.irq = 1'b0;
        end else if (pre_ld_i) begin
            core_d.pre = ld_val_i;
        end else if (cnt_ld_i) begin
            core_d.cnt = ld_val_i;
        end else if (tick_i) begin
            core_d.pre = pre_step;
            if (pre_wrap) begin
                core_d.cnt = cnt_step;
                if (cnt_wrap) begin
                    core_d.irq = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign irq_o = core_q.irq;

    AST_DIS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> !core_q.irq) // R3
        else $error("disable left irq high");

    AST_DIS_PRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> (core_q.pre == '0)) // R3
        else $error("disable left prescaler nonzero");

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.irq && !dis_i) |=> core_q.irq) // R8
        else $error("irq dropped without disable");

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.irq) |-> $past(tick_i && !dis_i && !pre_ld_i && !cnt_ld_i &&
            (down_i ? (core_q.cnt == '0) : (core_q.cnt == '1)))) // R8
        else $error("irq rose without counter wrap");

    AST_NARROW_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && narrow_i && !dis_i && !pre_ld_i && !cnt_ld_i)
        |=> (core_q.pre[W-1:NARROW_BITS] == $past(core_q.pre[W-1:NARROW_BITS]))) // R6
        else $error("narrow mode moved upper prescaler bits");

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !dis_i && !pre_ld_i && !cnt_ld_i) |=> $stable(core_q)) // R3
        else $error("state moved without cause");

endmodule

// File: rtl/evt_irq_timer.sv
module evt_irq_timer
    import evt_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter int                NARROW_BITS = 3,
    parameter logic [PAGE_W-1:0] PAGE        = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              evt_cpu_clk,
    input  logic              evt_ppu_a12,
    input  logic              evt_ppu_rd,
    input  logic              evt_cpu_wr,
    output logic              irq
);

    logic               en;
    dir_e               dir;
    logic               narrow;
    logic [1:0]         src;
    logic               dis, pre_ld, cnt_ld;
    logic [DATA_W-1:0]  ld_val;
    logic [NUM_SRC-1:0] strobes;
    logic               tick, down;

    assign strobes = {evt_cpu_wr, evt_ppu_rd, evt_ppu_a12, evt_cpu_clk};

    evt_reg_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE   (PAGE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .en_o     (en),
        .dir_o    (dir),
        .narrow_o (narrow),
        .src_o    (src),
        .dis_o    (dis),
        .pre_ld_o (pre_ld),
        .cnt_ld_o (cnt_ld),
        .ld_val_o (ld_val)
    );

    evt_src_select u_sel (
        .en_i     (en),
        .dir_i    (dir),
        .src_i    (src),
        .strobe_i (strobes),
        .tick_o   (tick),
        .down_o   (down)
    );

    evt_count_core #(
        .W           (DATA_W),
        .NARROW_BITS (NARROW_BITS)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .down_i   (down),
        .narrow_i (narrow),
        .dis_i    (dis),
        .pre_ld_i (pre_ld),
        .cnt_ld_i (cnt_ld),
        .ld_val_i (ld_val),
        .irq_o    (irq)
    );

    AST_DISABLED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !$rose(irq)) // R3
        else $error("irq rose while disabled");

endmodule

// File: tb/evt_irq_timer_tb_top.sv
module evt_irq_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  ev = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    evt_irq_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .evt_cpu_clk (ev[0]),
        .evt_ppu_a12 (ev[1]),
        .evt_ppu_rd  (ev[2]),
        .evt_cpu_wr  (ev[3]),
        .irq         (irq)
    );

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int s, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev[s] = 1'b1;
            @(negedge clk);
            ev = '0;
        end
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic fire_at(input int s, input int n, input string tag);
        pulse(s, n - 1);
        expect_irq(1'b0, tag);
        pulse(s, 1);
        expect_irq(1'b1, tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #3;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (irq !== it.exp) begin
                    bad++;
                    $display("FAIL %s: irq actual=%0b expected=%0b", it.tag, irq, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_irq(1'b0, "R9 reset irq low");

        // R9: direction defaults to hold, so nothing counts
        bus_wr(16'hC003, 8'h00);
        pulse(0, 20);
        expect_irq(1'b0, "R9 default hold");

        // R5 R6 R8: up, narrow, source 0, key 0 after reset (R4)
        bus_wr(16'hC001, 8'h44);
        bus_wr(16'hC004, 8'h00);
        bus_wr(16'hC005, 8'hFF);
        pulse(1, 12); pulse(2, 12); pulse(3, 12);
        expect_irq(1'b0, "R5 other sources ignored");
        fire_at(0, 8, "R6 narrow wrap at 8");
        pulse(0, 3);
        expect_irq(1'b1, "R8 irq sticky");

        // R3: disable acknowledges
        bus_wr(16'hC002, 8'h00);
        expect_irq(1'b0, "R3 disable clears irq");

        // R3 R2: disable clears prescaler
        bus_wr(16'hC005, 8'hFF);
        bus_wr(16'hC004, 8'h05);
        pulse(0, 10);
        bus_wr(16'hC000, 8'h00);
        bus_wr(16'hC000, 8'h01);
        fire_at(0, 8, "R3 prescaler cleared by disable");
        bus_wr(16'hC000, 8'hFE);
        expect_irq(1'b0, "R2 reg0 bit0 clear disables");

        // R7: hold directions
        bus_wr(16'hC001, 8'hC4);
        bus_wr(16'hC004, 8'h00);
        bus_wr(16'hC005, 8'hFF);
        bus_wr(16'hC003, 8'h00);
        pulse(0, 20);
        expect_irq(1'b0, "R7 direction 3 holds");
        bus_wr(16'hC001, 8'h04);
        pulse(0, 20);
        expect_irq(1'b0, "R7 direction 0 holds");
        bus_wr(16'hC001, 8'h44);
        fire_at(0, 8, "R7 up after hold");

        // R1: address decode
        bus_wr(16'hC002, 8'h00);
        bus_wr(16'hC804, 8'h00);
        bus_wr(16'hCFFD, 8'hFF);
        bus_wr(16'hD005, 8'h00);
        bus_wr(16'hB005, 8'h00);
        bus_wr(16'hD003, 8'h00);
        pulse(0, 8);
        expect_irq(1'b0, "R1 off-page enable ignored");
        bus_wr(16'hC7FB, 8'h00);
        fire_at(0, 8, "R1 A11 and middle bits ignored");
        bus_wr(16'hD002, 8'h00);
        bus_wr(16'hE000, 8'h00);
        expect_irq(1'b1, "R1 off-page disable ignored");

        // R4: XOR key
        bus_wr(16'hC002, 8'h00);
        bus_wr(16'hC006, 8'h5A);
        bus_wr(16'hC004, 8'h5A);
        bus_wr(16'hC005, 8'hA5);
        bus_wr(16'hC003, 8'h00);
        fire_at(0, 8, "R4 keyed loads");

        // R6: narrow keeps upper bits, pre=0xFD -> 3 steps
        bus_wr(16'hC002, 8'h00);
        bus_wr(16'hC004, 8'hA7);
        bus_wr(16'hC005, 8'hA5);
        bus_wr(16'hC003, 8'h00);
        fire_at(0, 3, "R6 narrow low bits only");

        // R7: down counting, source 1
        bus_wr(16'hC002, 8'h00);
        bus_wr(16'hC006, 8'h00);
        bus_wr(16'hC001, 8'h85);
        bus_wr(16'hC004, 8'h03);
        bus_wr(16'hC005, 8'h00);
        bus_wr(16'hC003, 8'h00);
        fire_at(1, 4, "R7 down wrap");

        // R6: full mask, source 2
        bus_wr(16'hC002, 8'h00);
        bus_wr(16'hC001, 8'h42);
        bus_wr(16'hC004, 8'h00);
        bus_wr(16'hC005, 8'hFF);
        bus_wr(16'hC003, 8'h00);
        fire_at(2, 256, "R6 full wrap at 256");

        // R10: aux register and mode bit 3, source 3
        bus_wr(16'hC002, 8'h00);
        bus_wr(16'hC001, 8'h4F);
        bus_wr(16'hC007, 8'hFF);
        bus_wr(16'hC004, 8'h00);
        bus_wr(16'hC005, 8'hFF);
        bus_wr(16'hC003, 8'h00);
        bus_wr(16'hC007, 8'h00);
        fire_at(3, 8, "R10 aux no effect");

        // R8: counter needs two prescaler wraps
        bus_wr(16'hC002, 8'h00);
        bus_wr(16'hC001, 8'h44);
        bus_wr(16'hC005, 8'hFE);
        bus_wr(16'hC004, 8'h00);
        bus_wr(16'hC003, 8'h00);
        fire_at(0, 16, "R8 two prescaler wraps");

        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule